// File: doc/BRIEF.md
# USB Data CRC16 Byte Checker

This block checks the 16-bit cyclic redundancy code carried by USB data packets on the receive side. Bytes come in already recovered from the line, without the packet identifier, one byte for each cycle that the valid strobe is high. The register works in reflected form, least significant bit first. Each byte is folded in within one clock by a combinational eight-step update. When the caller signals the end of the packet, the block raises a one-cycle done pulse with a pass/fail flag. The flag is set when the register holds the fixed residual that any error-free data field, followed by its own two complemented CRC bytes, leaves behind.

A start input opens each packet and loads the seed. A mode input picks one of two seeds. The first is the plain all-ones seed. The second is a pre-charged seed that stands in for a leading dummy zero byte: the block absorbs that dummy in the same cycle as the first real byte, so the final results of the two modes are identical.

Top module: `usb_crc16_chk`

## Requirements
- R1: While reset is asserted and right after it, crc_o reads 0xFFFF and done_o and crc_ok_o are 0.
- R2: A cycle with start_i high and seed_pre_i low loads 0xFFFF into the register, and crc_o shows that value in the next cycle.
- R3: A cycle with start_i high and seed_pre_i high loads 0xFE54. The first accepted byte after that first folds in a zero byte and then the real byte, in one cycle. From that byte on, crc_o matches the value the 0xFFFF seed would give.
- R4: Each cycle with byte_vld_i high and start_i low updates the register as new = T[low8(crc) XOR byte] XOR (crc >> 8). T[i] is i shifted right eight times, XORed with 0xA001 after each shift in which a 1 fell out. The new value shows on crc_o in the next cycle.
- R5: In a cycle with byte_vld_i and start_i both low, byte_i has no effect and crc_o holds its value.
- R6: pkt_end_i high in a cycle makes done_o high for exactly the next cycle. A byte accepted in that same cycle is part of the packet.
- R7: crc_ok_o is high only together with done_o. It is high when the register after the packet equals 0xB001 and at least two bytes were accepted since the last start.
- R8: When start_i and byte_vld_i are high in the same cycle, start_i wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Open a packet and load the seed |
| seed_pre_i | input | 1 | Seed mode: 1 selects the pre-charged seed 0xFE54 |
| byte_i | input | 8 | Received data or CRC byte |
| byte_vld_i | input | 1 | byte_i is valid this cycle |
| pkt_end_i | input | 1 | Last byte of the packet has been given |
| crc_o | output | 16 | Current register value |
| done_o | output | 1 | One-cycle pulse after pkt_end_i |
| crc_ok_o | output | 1 | Residual matched, valid with done_o |

## Verification
Intact packets of several lengths are sent, from a zero-length data field up to many bytes. This separates a correct byte update from one that is off by a bit order or by a shift, because a wrong update makes the residual miss. Packets with one flipped bit, and packets too short to count, show that the pass flag follows both the residual and the byte count. Each packet is sent in both seed modes, which shows that the pre-charged seed ends at the same value as the plain seed. Idle gaps with a changing byte_i, and a start that collides with a byte strobe, check that unstrobed or overridden bytes leave the register alone.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;
  localparam logic [CRC_W-1:0] SEED_STD  = 16'hFFFF;
  localparam logic [CRC_W-1:0] SEED_PRE  = 16'hFE54;
  localparam logic [CRC_W-1:0] RESIDUE   = 16'hB001;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/usb_crc16_step.sv
// One full byte step of the reflected CRC, built from BYTE_W shift stages.
module usb_crc16_step #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'hA001
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int unsigned PAD_W = CRC_W - BYTE_W;

  logic [CRC_W-1:0] stage [0:BYTE_W];

  assign stage[0] = {{PAD_W{1'b0}}, crc_i[BYTE_W-1:0] ^ byte_i};

  for (genvar k = 0; k < BYTE_W; k++) begin : g_shift
    assign stage[k+1] = (stage[k] >> 1) ^ (stage[k][0] ? POLY : '0);
  end

  assign crc_o = stage[BYTE_W] ^ (crc_i >> BYTE_W);
endmodule

// File: rtl/usb_crc16_core.sv
// CRC register with seed selection and absorption of the dummy zero byte.
module usb_crc16_core
  import usb_crc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              seed_pre_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output crc_t              crc_q_o,
  output crc_t              crc_nxt_o
);
  crc_t crc_q, crc_d, dummy_out, step_in, step_out;
  logic pend_q, pend_d;
  logic reg_en;

  usb_crc16_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY_REFL)) u_dummy (
    .crc_i (crc_q),
    .byte_i('0),
    .crc_o (dummy_out)
  );

  assign step_in = pend_q ? dummy_out : crc_q;

  usb_crc16_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY_REFL)) u_data (
    .crc_i (step_in),
    .byte_i(byte_i),
    .crc_o (step_out)
  );

  always_comb begin
    crc_d  = crc_q;
    pend_d = pend_q;
    if (start_i) begin
      crc_d  = seed_pre_i ? SEED_PRE : SEED_STD;
      pend_d = seed_pre_i;
    end else if (take_i) begin
      crc_d  = step_out;
      pend_d = 1'b0;
    end
  end

  assign reg_en = start_i | take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= SEED_STD;
      pend_q <= 1'b0;
    end else if (reg_en) begin
      crc_q  <= crc_d;
      pend_q <= pend_d;
    end
  end

  assign crc_q_o   = crc_q;
  assign crc_nxt_o = crc_d;
endmodule

// File: rtl/usb_crc16_ctl.sv
// Byte counting and the end-of-packet verdict.
module usb_crc16_ctl
  import usb_crc16_pkg::*;
#(
  parameter int unsigned MIN_BYTES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic take_i,
  input  logic pkt_end_i,
  input  crc_t crc_nxt_i,
  output logic done_o,
  output logic ok_o
);
  localparam int unsigned CNT_W = $clog2(MIN_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic done_q, done_d, ok_q, ok_d;
  logic cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)
      cnt_d = '0;
    else if (take_i && cnt_q < CNT_MAX)
      cnt_d = cnt_q + 1'b1;
    done_d = pkt_end_i;
    ok_d   = pkt_end_i && (crc_nxt_i == RESIDUE) && (cnt_d >= CNT_MAX);
  end

  assign cnt_en = start_i | take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;
endmodule

// File: rtl/usb_crc16_chk.sv
module usb_crc16_chk
  import usb_crc16_pkg::*;
#(
  parameter int unsigned MIN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              seed_pre_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              pkt_end_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o,
  output logic              crc_ok_o
);
  crc_t crc_nxt;
  logic take;

  assign take = byte_vld_i & ~start_i;

  usb_crc16_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .seed_pre_i(seed_pre_i),
    .take_i    (take),
    .byte_i    (byte_i),
    .crc_q_o   (crc_o),
    .crc_nxt_o (crc_nxt)
  );

  usb_crc16_ctl #(.MIN_BYTES(MIN_BYTES)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .take_i   (take),
    .pkt_end_i(pkt_end_i),
    .crc_nxt_i(crc_nxt),
    .done_o   (done_o),
    .ok_o     (crc_ok_o)
  );
endmodule

// File: rtl/usb_crc16_chk_sva.sv
module usb_crc16_chk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        seed_pre_i,
  input logic        byte_vld_i,
  input logic        pkt_end_i,
  input logic [15:0] crc_o,
  input logic        done_o,
  input logic        crc_ok_o
);
  AST_STD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !seed_pre_i |=> crc_o == 16'hFFFF); // R2
  AST_PRE_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && seed_pre_i |=> crc_o == 16'hFE54); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !byte_vld_i |=> $stable(crc_o)); // R5
  AST_DONE_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_i |=> done_o); // R6
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end_i |=> !done_o); // R6
  AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok_o |-> done_o && crc_o == 16'hB001); // R7
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && byte_vld_i && !seed_pre_i |=> crc_o == 16'hFFFF); // R8
endmodule

bind usb_crc16_chk usb_crc16_chk_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .seed_pre_i(seed_pre_i),
  .byte_vld_i(byte_vld_i),
  .pkt_end_i (pkt_end_i),
  .crc_o     (crc_o),
  .done_o    (done_o),
  .crc_ok_o  (crc_ok_o)
);

// File: tb/tb_usb_crc16_chk.sv
module tb_usb_crc16_chk;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, seed_pre_i, byte_vld_i, pkt_end_i;
  logic [7:0]  byte_i;
  logic [15:0] crc_o;
  logic        done_o, crc_ok_o;

  int total = 0;
  int bad   = 0;
  logic [16:0] exp_q[$];
  logic [7:0]  pkt[$];

  always #(PERIOD/2) clk = ~clk;

  usb_crc16_chk dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_pre_i(seed_pre_i),
    .byte_i(byte_i), .byte_vld_i(byte_vld_i), .pkt_end_i(pkt_end_i),
    .crc_o(crc_o), .done_o(done_o), .crc_ok_o(crc_ok_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-serial reference, independent of the byte-table form
  function automatic logic [15:0] ref_crc(input logic [15:0] init, input logic [7:0] q[$]);
    logic [15:0] c = init;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ q[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  // monitor: compare verdicts against scoreboard queue
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      logic [16:0] e;
      if (exp_q.size() == 0) begin
        check("R6 unexpected done", 32'(done_o), 32'h0);
      end else begin
        e = exp_q.pop_front();
        check("R7 crc_ok", 32'(crc_ok_o), 32'(e[16]));
        check("R4 final crc", 32'(crc_o), 32'(e[15:0]));
      end
    end
  end

  task automatic idle;
    @(negedge clk);
    start_i = 0; byte_vld_i = 0; pkt_end_i = 0; byte_i = $urandom;
  endtask

  task automatic send(input logic pre);
    logic [15:0] r = ref_crc(16'hFFFF, pkt);
    exp_q.push_back({(r == 16'hB001) && (pkt.size() >= 2), r});
    @(negedge clk);
    start_i = 1; seed_pre_i = pre; byte_vld_i = 0; pkt_end_i = 0;
    @(negedge clk);
    check(pre ? "R3 pre seed" : "R2 std seed", 32'(crc_o), pre ? 32'hFE54 : 32'hFFFF);
    start_i = 0;
    if (pkt.size() == 0) pkt_end_i = 1;
    foreach (pkt[i]) begin
      byte_i = pkt[i]; byte_vld_i = 1;
      pkt_end_i = (i == pkt.size() - 1);
      if (i == 0) begin
        @(negedge clk);
        byte_vld_i = 0; pkt_end_i = 0;
        if (pkt.size() > 1) begin
          logic [7:0] one[$];
          one.push_back(pkt[0]);
          check("R3/R4 first byte", 32'(crc_o), 32'(ref_crc(16'hFFFF, one)));
        end
      end else begin
        @(negedge clk);
        byte_vld_i = 0; pkt_end_i = 0;
      end
    end
    idle();
    idle();
  endtask

  task automatic make_good(input int n);
    logic [15:0] c;
    pkt.delete();
    for (int i = 0; i < n; i++) pkt.push_back(8'($urandom));
    c = ~ref_crc(16'hFFFF, pkt);
    pkt.push_back(c[7:0]);
    pkt.push_back(c[15:8]);
  endtask

  initial begin
    rst_n = 0; start_i = 0; seed_pre_i = 0; byte_vld_i = 0; pkt_end_i = 0; byte_i = 0;
    #(PERIOD*2 + 1);
    check("R1 crc reset", 32'(crc_o), 32'hFFFF);
    check("R1 done reset", 32'(done_o), 32'h0);
    check("R1 ok reset", 32'(crc_ok_o), 32'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 crc after reset", 32'(crc_o), 32'hFFFF);

    // good packets, both seed modes
    for (int n = 0; n < 9; n++) begin
      make_good(n * 3);
      send(1'b0);
      send(1'b1);
    end
    // corrupted packets
    for (int n = 1; n < 6; n++) begin
      make_good(n * 2);
      pkt[0] = pkt[0] ^ 8'(1 << (n % 8));
      send(n[0]);
    end
    // too-short packets
    pkt.delete(); send(1'b0);
    pkt.delete(); pkt.push_back(8'hA5); send(1'b1);

    // R5: unstrobed bytes ignored
    pkt.delete(); pkt.push_back(8'h3C);
    @(negedge clk); start_i = 1; seed_pre_i = 0;
    @(negedge clk); start_i = 0; byte_i = 8'h3C; byte_vld_i = 1;
    @(negedge clk); byte_vld_i = 0;
    for (int i = 0; i < 4; i++) begin
      byte_i = 8'(i * 37 + 5);
      @(negedge clk);
      check("R5 hold", 32'(crc_o), 32'(ref_crc(16'hFFFF, pkt)));
    end

    // R8: start beats a simultaneous byte
    @(negedge clk); start_i = 1; seed_pre_i = 0; byte_vld_i = 1; byte_i = 8'h81;
    @(negedge clk); start_i = 0; byte_vld_i = 0;
    check("R8 start wins", 32'(crc_o), 32'hFFFF);

    // R6: done is a single pulse
    @(negedge clk); pkt_end_i = 1;
    exp_q.push_back({1'b0, 16'hFFFF});
    @(negedge clk); pkt_end_i = 0;
    check("R6 done high", 32'(done_o), 32'h1);
    @(negedge clk);
    check("R6 done low", 32'(done_o), 32'h0);
    check("R6 queue drained", 32'(exp_q.size()), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule